// File: doc/BRIEF.md
# Bus-Attached Shift Register

A short clocked register that hangs on a shared parallel data bus. Each cell holds one bit. On a clock edge the register can capture a word from the bus, move its contents one place along a serial chain, or fill every cell with ones. Between those operations it keeps its value. The stored word goes back onto the bus only while a read enable is high. At all other times the read port floats, so other agents can own the bus.

All state changes happen on the rising clock edge and are controlled by synchronous enables, with no gated clock. Three controls can be active together, so the block resolves them in a fixed order:

1. Synchronous reset.
2. Preset, which only acts together with a write.
3. Parallel load.
4. Serial shift.

When none of these applies, the register holds. Serial data enters at cell 0 and leaves from the highest-numbered cell. Used as a delay line, the register therefore delays a bit by as many clocks as it has cells.

Top module: `bus_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, every cell becomes 0, whatever the other controls are.
- R2: When `wr_en` is high, `preset` is low and `rst` is low at an edge, cell i takes `bus_in[i]`. Cell i is visible on `bus_out[i]`.
- R3: When `sh_en` is high and `wr_en` is low at an edge, cell 0 takes `ser_in` and cell i takes the old cell i-1. `ser_out` always equals the highest cell.
- R4: When `wr_en` and `preset` are both high at an edge, every cell becomes 1 and `bus_in` is ignored.
- R5: When `preset` is high and `wr_en` is low, `preset` has no effect. The register shifts if `sh_en` is high and holds otherwise.
- R6: When `wr_en` and `sh_en` are both high (and `preset` is low), the parallel load wins and `ser_in` is ignored.
- R7: When `wr_en` and `sh_en` are both low, every cell keeps its value.
- R8: While `rd_en` is high, `bus_out` drives the stored word. While `rd_en` is low, every bit of `bus_out` is high impedance, so a weak pull-up on the bus reads all ones. Reading never changes the cells.
- R9: With `sh_en` held high and no write, a 1 presented on `ser_in` for one clock reaches `ser_out` exactly WIDTH clocks later (4 with defaults), and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | WIDTH | Parallel word from the shared bus |
| ser_in | input | 1 | Serial data entering cell 0 |
| wr_en | input | 1 | Parallel write enable (also qualifies preset) |
| sh_en | input | 1 | Serial shift enable |
| rd_en | input | 1 | Drive the stored word onto the bus |
| preset | input | 1 | Fill all cells with ones when written |
| bus_out | output | WIDTH | Tri-stated parallel read port |
| ser_out | output | 1 | Serial data from the last cell |

## Verification
The bench targets the points where the enables collide:

- **Load and shift together.** A design that let the shift win would put the shifted word instead of the bus word into the register.
- **Preset without a write.** A design that ignored the write qualification would fill the register with ones.
- **Preset with a write and a zero data word.** A wrong priority would load zeros.

The read port is observed through a pull-up. A port that drives zeros, or the stale word, while not selected would show up as a value other than all ones. A serial bit is timed through the chain, which exposes a chain one stage short or long and a reversed shift direction. A reset applied while a write is pending confirms that reset takes precedence over every other control.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   // Operation chosen for the current edge, highest priority first in decode
   typedef enum logic [1:0] {
      BSR_HOLD  = 2'd0,
      BSR_SHIFT = 2'd1,
      BSR_LOAD  = 2'd2,
      BSR_FILL  = 2'd3
   } bsr_op_e;

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
   import bsr_pkg::*;
(
   input  logic    wr_en,
   input  logic    sh_en,
   input  logic    preset,
   output bsr_op_e op
);

   // Fixed priority: fill (preset qualified by write) > load > shift > hold
   always_comb begin
      if (wr_en && preset)
         op = BSR_FILL;
      else if (wr_en)
         op = BSR_LOAD;
      else if (sh_en)
         op = BSR_SHIFT;
      else
         op = BSR_HOLD;
   end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
   import bsr_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  bsr_op_e op,
   input  logic    par_bit,
   input  logic    chain_bit,
   output logic    q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= 1'b0;
      else begin
         case (op)
            BSR_FILL:  q <= 1'b1;
            BSR_LOAD:  q <= par_bit;
            BSR_SHIFT: q <= chain_bit;
            default:   q <= q;
         endcase
      end
   end

   // R4: a qualified preset leaves this cell at one
   assert_fill_sets_one_R4: assert property (
      @(posedge clk) disable iff (rst) (op == BSR_FILL) |=> q
   ) else $error("cell not set by preset");

endmodule

// File: rtl/bsr_rdport.sv
module bsr_rdport #(
   parameter int WIDTH = 4
) (
   input  logic             rd_en,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] bus_out
);

   // One tri-state driver per bus line
   for (genvar b = 0; b < WIDTH; b++) begin : g_drv
      assign bus_out[b] = rd_en ? word[b] : 1'bz;
   end

endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
   import bsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] bus_in,
   input  logic             ser_in,
   input  logic             wr_en,
   input  logic             sh_en,
   input  logic             rd_en,
   input  logic             preset,
   output logic [WIDTH-1:0] bus_out,
   output logic             ser_out
);

   localparam int LAST = WIDTH - 1;

   // Elaboration-time parameter check
   if (WIDTH < 2) begin : g_width_check
      $error("bus_shift_reg: WIDTH must be at least 2");
   end

   bsr_op_e          op;
   logic [WIDTH-1:0] word;
   logic [WIDTH-1:0] chain_in;

   bsr_ctrl u_ctrl (
      .wr_en  (wr_en),
      .sh_en  (sh_en),
      .preset (preset),
      .op     (op)
   );

   // Serial chain: cell 0 fed from ser_in, cell i from cell i-1
   assign chain_in = {word[LAST-1:0], ser_in};

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      bsr_cell u_cell (
         .clk       (clk),
         .rst       (rst),
         .op        (op),
         .par_bit   (bus_in[i]),
         .chain_bit (chain_in[i]),
         .q         (word[i])
      );
   end

   assign ser_out = word[LAST];

   bsr_rdport #(.WIDTH(WIDTH)) u_rd (
      .rd_en   (rd_en),
      .word    (word),
      .bus_out (bus_out)
   );

   // ---------------- assertions ----------------
   assert_reset_clears_R1: assert property (
      @(posedge clk) rst |=> (word == '0)
   ) else $error("reset did not clear cells");

   assert_load_word_R2: assert property (
      @(posedge clk) disable iff (rst)
      (wr_en && !preset && !sh_en) |=> (word == $past(bus_in))
   ) else $error("parallel load mismatch");

   assert_shift_step_R3: assert property (
      @(posedge clk) disable iff (rst)
      (sh_en && !wr_en) |=> (word == {$past(word[LAST-1:0]), $past(ser_in)})
   ) else $error("shift step mismatch");

   assert_preset_needs_write_R5: assert property (
      @(posedge clk) disable iff (rst)
      (preset && !wr_en && !sh_en) |=> $stable(word)
   ) else $error("preset acted without write");

   assert_load_beats_shift_R6: assert property (
      @(posedge clk) disable iff (rst)
      (wr_en && sh_en && !preset) |=> (word == $past(bus_in))
   ) else $error("shift overrode load");

   assert_idle_holds_R7: assert property (
      @(posedge clk) disable iff (rst)
      (!wr_en && !sh_en) |=> $stable(word)
   ) else $error("register changed while idle");

   assert_read_drives_R8: assert property (
      @(posedge clk) disable iff (rst)
      rd_en |-> (bus_out == word)
   ) else $error("read port not driving stored word");

endmodule

// File: tb/tb_bus_shift_reg.sv
module tb_bus_shift_reg;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] bus_in;
   logic         ser_in, wr_en, sh_en, rd_en, preset;
   wire  [W-1:0] bus_w;
   logic         ser_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   for (genvar p = 0; p < W; p++) begin : g_pull
      pullup (bus_w[p]);
   end

   bus_shift_reg #(.WIDTH(W)) dut (
      .clk     (clk),
      .rst     (rst),
      .bus_in  (bus_in),
      .ser_in  (ser_in),
      .wr_en   (wr_en),
      .sh_en   (sh_en),
      .rd_en   (rd_en),
      .preset  (preset),
      .bus_out (bus_w),
      .ser_out (ser_out)
   );

   // Row: {wr, sh, pre, rd, si, bus[3:0], expected cells[3:0], expected ser_out}
   localparam logic [13:0] VECS [16] = '{
      14'b1_0_0_1_0_1010_1010_1,   // load
      14'b0_1_0_1_1_0000_0101_0,   // shift in 1
      14'b0_1_0_0_0_0000_1010_1,   // shift, bus released
      14'b0_0_0_1_0_1111_1010_1,   // idle hold
      14'b0_0_1_1_0_0000_1010_1,   // preset alone ignored
      14'b1_1_0_1_1_0011_0011_0,   // load beats shift
      14'b1_0_1_1_0_0000_1111_1,   // preset with write
      14'b1_0_0_1_0_0000_0000_0,   // clear by load
      14'b0_1_0_1_1_0000_0001_0,
      14'b0_1_0_1_0_0000_0010_0,
      14'b0_1_0_1_0_0000_0100_0,
      14'b0_1_0_1_0_0000_1000_1,
      14'b0_1_0_0_0_0000_0000_0,   // shift out, bus released
      14'b0_1_1_1_1_0000_0001_0,   // preset during shift ignored
      14'b1_0_0_1_0_0110_0110_0,   // load
      14'b0_0_0_0_0_0000_0110_0    // idle, bus released
   };

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic s, input logic pr,
                        input logic r, input logic si, input logic [W-1:0] b);
      wr_en = w; sh_en = s; preset = pr; rd_en = r; ser_in = si; bus_in = b;
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst = 1'b1;
      drive(0, 0, 0, 1, 0, '0);
      @(negedge clk);
      step();
      step();
      // R1: reset state
      check("R1", "reset word", bus_w, 4'b0000);
      check("R1", "reset ser_out", {3'b0, ser_out}, 4'b0000);
      rst = 1'b0;

      for (int k = 0; k < 16; k++) begin
         logic [13:0] v;
         string       tag;
         v = VECS[k];
         drive(v[13], v[12], v[11], v[10], v[9], v[8:5]);
         if (v[13] && v[11])      tag = "R4";
         else if (v[13] && v[12]) tag = "R6";
         else if (v[13])          tag = "R2";
         else if (v[11])          tag = "R5";
         else if (v[12])          tag = "R3";
         else                     tag = "R7";
         step();
         check(tag, "ser_out", {3'b0, ser_out}, {3'b0, v[0]});
         if (v[10])
            check(tag, "bus word", bus_w, v[4:1]);
         else
            check("R8", "released bus", bus_w, 4'b1111);
      end

      // R8: read after release shows the unchanged word
      drive(0, 0, 0, 1, 0, '0);
      #1;
      check("R8", "read unchanged", bus_w, 4'b0110);

      // R9: serial latency equals cell count
      drive(1, 0, 0, 1, 0, 4'b0000);
      step();
      drive(0, 1, 0, 0, 1, '0);
      step();
      ser_in = 1'b0;
      for (int c = 2; c <= W + 1; c++) begin
         step();
         check("R9", "serial latency", {3'b0, ser_out}, {3'b0, (c == W)});
      end

      // R1: reset wins over a pending write
      drive(1, 0, 0, 1, 0, 4'b1111);
      step();
      check("R2", "load ones", bus_w, 4'b1111);
      rst = 1'b1;
      drive(1, 1, 1, 1, 1, 4'b1010);
      step();
      rst = 1'b0;
      drive(0, 0, 0, 1, 0, '0);
      #1;
      check("R1", "reset over write", bus_w, 4'b0000);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule